// File: doc/BRIEF.md
# Walking-One Connectivity Test Mode

This block gives a chip a board-level connectivity test. A strap input is read once, a fixed number of clocks after reset is released, and that reading sets the mode until the next reset. When the strap read high, the chip enters test mode. A cascade of NAND stages then combines six digital inputs, and its result replaces the normal signal on a shared multi-function output pin. When the strap read low, the pin carries the normal interrupt or reset signal unchanged.

The inputs are ordered so that test equipment can check the board with a walking-one pattern. It starts with all inputs low. It then raises the input nearest the output, then the next, and so on, keeping each one high. Every step toggles the pin, so an open or shorted net shows up as a missing toggle.

The NAND cascade is combinational. Stage k computes the NAND of input k and the output of stage k+1. The farthest stage takes a constant 1 as its second operand, and stage 0 drives the pin.

Top module: `conn_test_top`

## Requirements
- R1: While reset is asserted, and after its release until the mode sample, the block is in normal mode: pin_o equals normal_i.
- R2: The mode is set from strap_i as it stands at the SAMPLE_DLY-th rising clock edge after reset is released (default 8). A high strap selects test mode and a low strap selects normal mode. Strap values on earlier edges have no effect.
- R3: After the sample, the mode stays fixed until the next reset, whatever strap_i does.
- R4: In test mode, pin_o is the NAND cascade output, with tree_in_i bit 0 nearest the output and bit 5 farthest.
- R5: In test mode with all tree inputs low, pin_o is 1.
- R6: In test mode, raising bits 0, 1, 2 and onward one at a time, holding each high, toggles pin_o at every step. After k bits are high, pin_o is 1 for even k and 0 for odd k.
- R7: In test mode, for any input pattern, pin_o is 1 exactly when the number of consecutive high bits counted from bit 0 is even. This count includes zero, so any pattern with bit 0 low gives 1.
- R8: In normal mode, pin_o equals normal_i for any value of tree_in_i.
- R9: In test mode, normal_i has no effect on pin_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Test-mode strap, sampled once after reset |
| tree_in_i | input | 6 | Digital inputs into the NAND cascade, bit 0 nearest the output |
| normal_i | input | 1 | Normal interrupt/reset signal for the shared pin |
| pin_o | output | 1 | Shared multi-function output pin |

## Verification
The pin path is combinational, so a change on tree_in_i or normal_i shows on pin_o in the same cycle. The bench drives inputs on the falling edge and samples the pin 2 ns later, with no clock edge between. The mode decision takes effect at the SAMPLE_DLY-th rising edge after release. The bench therefore counts falling edges from release and puts the intended strap value on the line only for the edge just before that sample edge, with the opposite value before and after. Both mode checks are made only once that edge has passed.

// File: rtl/conn_test_pkg.sv
package conn_test_pkg;
  typedef enum logic {
    PIN_NORMAL = 1'b0,
    PIN_TREE   = 1'b1
  } pin_src_e;
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int unsigned SAMPLE_DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic done_o,
  output logic mode_o
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_DLY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_DLY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        done_q <= 1'b1;
        mode_q <= strap_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/nand_chain.sv
module nand_chain #(
  parameter int unsigned NUM_IN = 6
) (
  input  logic [NUM_IN-1:0] in_i,
  output logic              out_o
);
  logic [NUM_IN:0] stage;

  assign stage[NUM_IN] = 1'b1;  // far end seed

  for (genvar k = 0; k < NUM_IN; k++) begin : g_stage
    assign stage[k] = ~(in_i[k] & stage[k+1]);
  end

  assign out_o = stage[0];
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import conn_test_pkg::*;
(
  input  pin_src_e sel_i,
  input  logic     normal_i,
  input  logic     tree_i,
  output logic     pin_o
);
  always_comb begin
    unique case (sel_i)
      PIN_TREE: pin_o = tree_i;
      default:  pin_o = normal_i;
    endcase
  end
endmodule

// File: rtl/conn_test_top.sv
module conn_test_top
  import conn_test_pkg::*;
#(
  parameter int unsigned NUM_IN     = 6,
  parameter int unsigned SAMPLE_DLY = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic [NUM_IN-1:0] tree_in_i,
  input  logic              normal_i,
  output logic              pin_o
);
  logic     sample_done;
  logic     test_mode;
  logic     tree_out;
  pin_src_e pin_sel;

  strap_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) i_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strap_i(strap_i),
    .done_o (sample_done),
    .mode_o (test_mode)
  );

  nand_chain #(.NUM_IN(NUM_IN)) i_chain (
    .in_i (tree_in_i),
    .out_o(tree_out)
  );

  assign pin_sel = test_mode ? PIN_TREE : PIN_NORMAL;

  pin_mux i_mux (
    .sel_i   (pin_sel),
    .normal_i(normal_i),
    .tree_i  (tree_out),
    .pin_o   (pin_o)
  );
endmodule

// File: rtl/conn_test_checker.sv
module conn_test_checker #(
  parameter int unsigned NUM_IN = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strap_i,
  input logic [NUM_IN-1:0] tree_in_i,
  input logic              normal_i,
  input logic              pin_o,
  input logic              sample_done,
  input logic              test_mode
);
  AST_IDLE_BEFORE_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_done |-> !test_mode);  // R1

  AST_MODE_FROM_STRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_done) |-> test_mode == $past(strap_i));  // R2

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_done |=> $stable(test_mode) && sample_done);  // R3

  AST_TREE_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode && tree_in_i == '0) |-> pin_o);  // R5

  AST_NORMAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode |-> pin_o == normal_i);  // R8
endmodule

bind conn_test_top conn_test_checker #(.NUM_IN(NUM_IN)) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strap_i    (strap_i),
  .tree_in_i  (tree_in_i),
  .normal_i   (normal_i),
  .pin_o      (pin_o),
  .sample_done(sample_done),
  .test_mode  (test_mode)
);

// File: tb/test_conn_test_top.sv
module test_conn_test_top;
  localparam int N = 6;
  localparam int DLY = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic strap_i = 1'b0;
  logic [N-1:0] tree_in_i = '0;
  logic normal_i = 1'b0;
  logic pin_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  conn_test_top #(.NUM_IN(N), .SAMPLE_DLY(DLY)) i_conn_test_top (
    .clk_i, .rst_ni, .strap_i, .tree_in_i, .normal_i, .pin_o
  );

  function automatic logic exp_tree(logic [N-1:0] v);
    int run = 0;
    for (int i = 0; i < N; i++) begin
      if (!v[i]) break;
      run++;
    end
    return (run % 2 == 0);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pin_o=%b expected %b (tree=%b normal=%b)", req, act, exp, tree_in_i, normal_i);
    end
  endtask

  // reset, then present strap value v only at the sample edge
  task automatic start_with(logic v);
    rst_ni = 1'b0;
    strap_i = ~v;
    @(negedge clk_i);
    normal_i = 1'b1; #2 check("R1 in reset", pin_o, 1'b1);
    normal_i = 1'b0; #2 check("R1 in reset", pin_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tree_in_i = '0;
    for (int i = 1; i < DLY; i++) begin
      @(negedge clk_i);
      normal_i = i[0];
      #2 check("R1 before sample", pin_o, normal_i);
    end
    strap_i = v;
    @(negedge clk_i);
    strap_i = ~v;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));

    // test mode
    start_with(1'b1);
    tree_in_i = '0; normal_i = 1'b0;
    #2 check("R2 test mode entered / R5 all low", pin_o, 1'b1);
    for (int k = 1; k <= N; k++) begin
      logic prev;
      prev = pin_o;
      @(negedge clk_i);
      tree_in_i[k-1] = 1'b1;
      #2 check("R6 walking one toggle", pin_o, ~prev);
      check("R6 walking one level", pin_o, (k % 2 == 0));
    end
    @(negedge clk_i);
    tree_in_i = 6'b100000;
    #2 check("R7 far only", pin_o, 1'b1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      tree_in_i = N'($urandom);
      normal_i = $urandom % 2;
      strap_i = $urandom % 2;
      #2 check("R7 R4 random pattern", pin_o, exp_tree(tree_in_i));
      normal_i = ~normal_i;
      #1 check("R9 normal ignored", pin_o, exp_tree(tree_in_i));
    end
    @(negedge clk_i);
    strap_i = 1'b0;
    repeat (3 * DLY) @(negedge clk_i);
    tree_in_i = 6'b000001;
    #2 check("R3 still test mode", pin_o, 1'b0);

    // normal mode
    start_with(1'b0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      tree_in_i = N'($urandom);
      normal_i = $urandom % 2;
      strap_i = $urandom % 2;
      #2 check("R2 R8 normal mode", pin_o, normal_i);
    end
    @(negedge clk_i);
    strap_i = 1'b1;
    repeat (3 * DLY) @(negedge clk_i);
    tree_in_i = 6'b000001;
    normal_i = 1'b1;
    #2 check("R3 still normal mode", pin_o, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule